// File: doc/BRIEF.md
# Shadow-Buffered PWM Channel

This block drives one pulse-width-modulated output from a single 32-bit control word. Software writes and reads the word over a plain register port: a write strobe, write data and combinational read data. The output frequency comes from a fractional phase accumulator. On every enabled clock it adds a programmable step, so one output period lasts 2^BASE_W / step clocks. The duty comes from an 8-bit on-time field. That field is stored inverted, so a larger value gives a shorter high time.

New step and on-time values land in a shadow copy. They reach the active copy, which drives the output, only after software sets the update-request bit. The transfer happens at the next output-cycle boundary, and at that same edge the request bit clears itself. While a request is outstanding the register ignores writes. Software therefore polls the request bit before it reprograms the channel.

Top module: `shadow_pwm_channel`

## Requirements
- R1: After reset the read data is all zeros, the output is low and no update is pending.
- R2: A write accepted while no update is pending loads the fields as follows. Bit 31 is the enable. Bit 30 is the update request. The step field sits at bits [8 +: BASE_W] and the on-time at bits [7:0]. Readback returns these shadow values, and the unused bits read as zero.
- R3: Shadow values written without an update request leave the output waveform unchanged.
- R4: A pending update copies the shadow step and on-time into the active pair at a cycle boundary, and the request bit clears on the same edge. While enabled with a nonzero step, a boundary is a clock at which accumulator + step carries out of BASE_W bits.
- R5: While the request bit reads 1, any write is ignored entirely: enable, request and both fields keep their values.
- R6: While enabled, the output is high exactly when the phase (the top 8 accumulator bits) is less than 255 minus the active on-time. An on-time of 255 keeps the output low, and 0 makes it low only at phase 255.
- R7: While enabled, the accumulator advances by the active step on every clock, modulo 2^BASE_W.
- R8: With enable cleared, the accumulator is zero from the next clock and the output is low. A pending update then commits on the next clock. Setting enable starts counting from phase zero.
- R9: An active step of zero freezes the accumulator, so the output holds the level of its current phase, and a pending update commits on the next clock.
- R10: Writing bit 30 as 0 never withdraws a pending update; only a boundary clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback (enable, request, shadow fields) |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions check on every cycle that the accumulator steps by the active value, freezes on a zero step and clears when disabled. They also check that the output stays low when disabled or at full inversion, that the shadow fields and enable stay put while a request is pending, and that a request survives every clock that is not a boundary. Only the bench scenarios can show the cycle at which a commit lands and the waveform that results. These include the switch from one frequency and duty to another, the ignored writes during a pending request, the untouched output after shadow-only writes, and the restart from phase zero after re-enabling.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   localparam int CW_W       = 32;
   localparam int EN_BIT     = 31;
   localparam int REQ_BIT    = 30;
   localparam int STEP_LSB   = 8;
   localparam int ONT_W      = 8;
   localparam int MAX_STEP_W = REQ_BIT - STEP_LSB;

   typedef struct packed {
      logic en;
      logic req;
   } ctl_flags_t;

   // high-time threshold from the inverted on-time field
   function automatic logic [ONT_W:0] high_limit(input logic [ONT_W-1:0] ont);
      return 9'd255 - {1'b0, ont};
   endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_chan_pkg::*;
#(
   parameter int STEP_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CW_W-1:0]      wr_data,
   input  logic                 commit_i,
   output ctl_flags_t           flags_o,
   output logic [STEP_W-1:0]    act_step_o,
   output logic [ONT_W-1:0]     act_ont_o,
   output logic [CW_W-1:0]      rd_data_o
);
   localparam int PAD_W = MAX_STEP_W - STEP_W;

   ctl_flags_t          flags_q;
   logic [STEP_W-1:0]   sh_step_q;
   logic [ONT_W-1:0]    sh_ont_q;
   logic [STEP_W-1:0]   act_step_q;
   logic [ONT_W-1:0]    act_ont_q;
   logic                accept;

   assign accept = wr_en && !flags_q.req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q    <= '0;
         sh_step_q  <= '0;
         sh_ont_q   <= '0;
         act_step_q <= '0;
         act_ont_q  <= '0;
      end else begin
         if (commit_i) begin
            act_step_q <= sh_step_q;
            act_ont_q  <= sh_ont_q;
         end
         if (accept) begin
            flags_q.en  <= wr_data[EN_BIT];
            flags_q.req <= wr_data[REQ_BIT];
            sh_step_q   <= wr_data[STEP_LSB +: STEP_W];
            sh_ont_q    <= wr_data[ONT_W-1:0];
         end else if (commit_i) begin
            flags_q.req <= 1'b0;
         end
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data_o = {flags_q.en, flags_q.req, {PAD_W{1'b0}}, sh_step_q, sh_ont_q};
      end else begin : g_full
         assign rd_data_o = {flags_q.en, flags_q.req, sh_step_q, sh_ont_q};
      end
   endgenerate

   assign flags_o    = flags_q;
   assign act_step_o = act_step_q;
   assign act_ont_o  = act_ont_q;
endmodule

// File: rtl/pwm_phase_accum.sv
module pwm_phase_accum #(
   parameter int STEP_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic [STEP_W-1:0]   step_i,
   output logic [STEP_W-1:0]   acc_o,
   output logic                wrap_o
);
   logic [STEP_W-1:0] acc_q;
   logic [STEP_W:0]   sum;

   assign sum    = {1'b0, acc_q} + {1'b0, step_i};
   assign wrap_o = en_i && sum[STEP_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (en_i)  acc_q <= sum[STEP_W-1:0];
      else            acc_q <= '0;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
   import pwm_chan_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic [7:0]         phase_i,
   input  logic [ONT_W-1:0]   ont_i,
   output logic               pwm_o
);
   logic hi;

   assign hi = en_i && ({1'b0, phase_i} < high_limit(ont_i));

   generate
      if (OUT_REG) begin : g_flop
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= hi;
         end
         assign pwm_o = pwm_q;
      end else begin : g_comb
         assign pwm_o = hi;
      end
   endgenerate
endmodule

// File: rtl/shadow_pwm_channel.sv
module shadow_pwm_channel
   import pwm_chan_pkg::*;
#(
   parameter int STEP_W  = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              pwm_out
);
   localparam int PH_LSB = STEP_W - 8;

   generate
      if (STEP_W < 8 || STEP_W > MAX_STEP_W) begin : g_bad_w
         $error("STEP_W must lie in 8..22");
      end
   endgenerate

   ctl_flags_t          flags;
   logic                en_q;
   logic [STEP_W-1:0]   act_step_q;
   logic [ONT_W-1:0]    act_ont_q;
   logic [STEP_W-1:0]   acc_q;
   logic                wrap;
   logic                boundary;
   logic                commit;

   assign en_q     = flags.en;
   assign boundary = !en_q || (act_step_q == '0) || wrap;
   assign commit   = flags.req && boundary;

   pwm_cfg_regs #(.STEP_W(STEP_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .commit_i   (commit),
      .flags_o    (flags),
      .act_step_o (act_step_q),
      .act_ont_o  (act_ont_q),
      .rd_data_o  (rd_data)
   );

   pwm_phase_accum #(.STEP_W(STEP_W)) accum_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_q),
      .step_i (act_step_q),
      .acc_o  (acc_q),
      .wrap_o (wrap)
   );

   pwm_duty_cmp #(.OUT_REG(OUT_REG)) cmp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_q),
      .phase_i (acc_q[PH_LSB +: 8]),
      .ont_i   (act_ont_q),
      .pwm_o   (pwm_out)
   );
endmodule

// File: rtl/shadow_pwm_channel_chk.sv
module shadow_pwm_channel_chk #(
   parameter int STEP_W  = 16,
   parameter bit OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       rd_data,
   input logic              pwm_out,
   input logic              en,
   input logic [STEP_W-1:0] acc,
   input logic [STEP_W-1:0] act_step,
   input logic [7:0]        act_ont
);
   logic [STEP_W:0] nxt;
   logic            carry;
   assign nxt   = {1'b0, acc} + {1'b0, act_step};
   assign carry = nxt[STEP_W];

   // R7: accumulator steps by the active value
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> acc == STEP_W'($past(acc) + $past(act_step)));

   // R8: disabled accumulator returns to zero
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> acc == '0);

   // R9: zero step freezes the accumulator
   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act_step == '0) |=> $stable(acc));

   // R5: pending request locks enable and shadow fields
   p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[30] |=> rd_data[31] == $past(rd_data[31]) && rd_data[29:0] == $past(rd_data[29:0]));

   // R10: request survives any non-boundary clock
   p_no_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[30] && en && act_step != '0 && !carry) |=> rd_data[30]);

   generate
      if (!OUT_REG) begin : g_comb_chk
         // R8: output low while disabled
         p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> !pwm_out);
         // R6: full inversion never drives high
         p_full_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (act_ont == 8'hFF) |-> !pwm_out);
      end else begin : g_reg_chk
         p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !pwm_out);
         p_full_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (act_ont == 8'hFF) |=> !pwm_out);
      end
   endgenerate
endmodule

bind shadow_pwm_channel shadow_pwm_channel_chk #(.STEP_W(STEP_W), .OUT_REG(OUT_REG)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_data  (rd_data),
   .pwm_out  (pwm_out),
   .en       (en_q),
   .acc      (acc_q),
   .act_step (act_step_q),
   .act_ont  (act_ont_q)
);

// File: tb/shadow_pwm_channel_tb_top.sv
module shadow_pwm_channel_tb_top;
   localparam int  B       = 16;
   localparam bit  OREG    = 1'b0;
   localparam longint MODV = longint'(1) << B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int errors = 0;
   int checks = 0;

   // reference model state
   longint acc_m = 0, shs_m = 0, sho_m = 0, as_m = 0, ao_m = 0;
   bit     en_m = 0, pend_m = 0, out_reg_m = 0;

   always #5 clk = ~clk;

   shadow_pwm_channel #(.STEP_W(B), .OUT_REG(OREG)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   function automatic bit hi_now();
      return en_m && ((acc_m >> (B-8)) < (255 - ao_m));
   endfunction

   function automatic logic [31:0] rd_exp();
      return {en_m, pend_m, 30'(shs_m << 8) | 30'(sho_m)};
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clock(input bit we, input logic [31:0] d);
      bit boundary, pend_old;
      longint sum;
      sum       = acc_m + as_m;
      boundary  = !en_m || as_m == 0 || sum >= MODV;
      pend_old  = pend_m;
      out_reg_m = hi_now();
      acc_m     = en_m ? sum % MODV : 0;
      if (pend_old && boundary) begin
         as_m = shs_m; ao_m = sho_m; pend_m = 0;
      end
      if (we && !pend_old) begin
         en_m = d[31]; pend_m = d[30];
         shs_m = longint'(d[8 +: B]); sho_m = longint'(d[7:0]);
      end
   endtask

   task automatic step(input bit we, input logic [31:0] d);
      bit eo;
      wr_en = we; wr_data = d;
      @(posedge clk);
      model_clock(we, d);
      #2;
      wr_en = 1'b0;
      eo = OREG ? out_reg_m : hi_now();
      chk(pwm_out == eo, "R6 output level", longint'(pwm_out), longint'(eo));
      chk(rd_data == rd_exp(), "R2 readback", longint'(rd_data), longint'(rd_exp()));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0);
   endtask

   function automatic logic [31:0] cw(input bit en, input bit req, input int stp, input int ont);
      return {en, req, 30'(longint'(stp) << 8) | 30'(ont & 255)};
   endfunction

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int highs;
      logic [31:0] snap;
      bit lvl;
      #23;
      // R1: reset state
      chk(rd_data == 32'h0, "R1 reset readback", longint'(rd_data), 0);
      chk(pwm_out == 1'b0, "R1 reset output", longint'(pwm_out), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2/R4: enable with request; commits at once since active step is zero
      step(1'b1, cw(1, 1, 16'h1000, 8'h7F));
      chk(rd_data[30] == 1'b1, "R2 request visible", longint'(rd_data[30]), 1);
      step(1'b0, '0);
      chk(rd_data[30] == 1'b0, "R9 commit on zero step", longint'(rd_data[30]), 0);
      idle(40);

      // R5/R10: request new values, then writes while pending are ignored
      step(1'b1, cw(1, 1, 16'h2000, 8'h00));
      snap = rd_data;
      step(1'b1, cw(0, 0, 16'h0123, 8'h55));
      chk(rd_data == snap, "R5 write ignored while pending", longint'(rd_data), longint'(snap));
      chk(rd_data[30] == 1'b1 || pend_m == 0, "R10 request kept", longint'(rd_data[30]), 1);
      for (int i = 0; i < 40 && rd_data[30]; i++) step(1'b0, '0);
      chk(rd_data[30] == 1'b0, "R4 request cleared at boundary", longint'(rd_data[30]), 0);
      idle(24);

      // R3: shadow-only write, output follows old active values
      step(1'b1, cw(1, 0, 16'h0800, 8'hC0));
      idle(40);
      chk(ao_m == 0, "R3 active on-time unchanged", ao_m, 0);

      // R6: full inversion keeps output low
      step(1'b1, cw(1, 1, 16'h1000, 8'hFF));
      for (int i = 0; i < 40 && rd_data[30]; i++) step(1'b0, '0);
      highs = 0;
      for (int i = 0; i < 64; i++) begin step(1'b0, '0); highs += int'(pwm_out); end
      chk(highs == 0, "R6 on-time 255 never high", highs, 0);

      // R7: near-maximum step wraps almost every clock
      step(1'b1, cw(1, 1, 16'hFFF0, 8'h10));
      for (int i = 0; i < 40 && rd_data[30]; i++) step(1'b0, '0);
      idle(30);

      // R9: zero step freezes phase and output level
      step(1'b1, cw(1, 1, 0, 8'h80));
      for (int i = 0; i < 40 && rd_data[30]; i++) step(1'b0, '0);
      lvl = pwm_out;
      idle(10);
      chk(pwm_out == lvl, "R9 frozen level", longint'(pwm_out), longint'(lvl));

      // R8: disable, then re-enable from phase zero
      step(1'b1, cw(0, 0, 16'h1000, 8'h40));
      idle(3);
      chk(pwm_out == 1'b0, "R8 output low when disabled", longint'(pwm_out), 0);
      step(1'b1, cw(0, 1, 16'h1000, 8'h40));
      step(1'b0, '0);
      chk(rd_data[30] == 1'b0, "R8 commit while disabled", longint'(rd_data[30]), 0);
      step(1'b1, cw(1, 0, 16'h1000, 8'h40));
      chk(acc_m == 0 && pwm_out == 1'b1, "R8 restart at phase zero", longint'(pwm_out), 1);
      idle(40);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule